// File: doc/BRIEF.md
# Debug bus access scheduler

This block sits between the command logic of a debug controller and the system bus. The command logic hands it a single memory access: a 24-bit address, an operand size code, a read/write flag and, for writes, the data. The scheduler decides when that access is placed on the bus. It does not return a result until the access has completed or has been given up.

With the handshake enabled and stealing off, the access must not disturb the running system. The scheduler therefore holds the access until a cycle in which the bus reports itself idle. If 512 core clock cycles go by without such a cycle, it drops the access. It then raises a sticky no-response status and pulses a request for a long acknowledge toward the handshake logic, so that the host sees an error. With stealing on, or with the handshake off, the access is issued in the next cycle whatever the bus is doing.

Read data comes back right-aligned in a 32-bit register with the unused upper bits cleared. Byte lanes on the bus are selected from the low address bits. Lane 0 is bits 7:0 and carries the byte at address offset 0 (little-endian lanes).

Top module: `dbg_bus_sched`

## Requirements
- R1: When the request is accepted with cfg_hs_en=1 and cfg_steal=0, bus_req stays low in every cycle where bus_idle is low, and is asserted in the first cycle in which bus_idle is high.
- R2: When the request is accepted with cfg_steal=1 or cfg_hs_en=0, bus_req is asserted in the first cycle after acceptance regardless of bus_idle, and done pulses for one cycle in the cycle after bus_req.
- R3: In wait mode, if bus_idle stays low for 512 consecutive cycles after acceptance (cycles 0 to 511), the access is abandoned: bus_req never rises, and done and ack_err_long are both high for one cycle in cycle 512. An idle cycle at cycle 511 still grants the access, with ack_err_long low.
- R4: An abandoned access sets sts_noresp. sts_noresp stays set through later successful accesses.
- R5: sts_noresp is cleared only by a one-cycle sts_clr, taking effect at the next clock edge.
- R6: Size code 00 enables one byte lane at addr[1:0]. Code 01 enables two lanes starting at lane 2*addr[1]. Codes 10 and 11 both enable all four lanes (bus_be one bit per byte lane, bit 0 = bits 7:0).
- R7: After a read, rdata holds the selected bytes right-aligned, with all bits above the operand size at zero.
- R8: For a write, bus_write is high and the low bytes of req_wdata appear on bus_wdata in the enabled lanes.
- R9: bus_addr carries the full 24-bit request address unchanged during the access.
- R10: The 512-cycle timeout restarts from zero with each accepted request.
- R11: req_valid is ignored while busy is high. The access in progress keeps its own address and size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_hs_en | input | 1 | Acknowledge handshake enabled |
| cfg_steal | input | 1 | Take a bus cycle without waiting for idle |
| req_valid | input | 1 | Start an access (accepted when busy is low) |
| req_addr | input | 24 | Access address |
| req_size | input | 2 | Operand size code |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data, right-aligned |
| busy | output | 1 | An access is pending |
| done | output | 1 | One-cycle completion pulse |
| ack_err_long | output | 1 | One-cycle request for a long acknowledge (abandoned access) |
| rdata | output | 32 | Right-aligned read data |
| sts_noresp | output | 1 | Sticky no-response status |
| sts_clr | input | 1 | Clear sts_noresp |
| bus_idle | input | 1 | Bus has no other master this cycle |
| bus_req | output | 1 | Access occupies the bus this cycle |
| bus_addr | output | 24 | Bus address |
| bus_write | output | 1 | Bus write strobe |
| bus_be | output | 4 | Byte lane enables |
| bus_wdata | output | 32 | Lane-placed write data |
| bus_rdata | input | 32 | Bus read data, sampled in the bus_req cycle |

## Verification
Cycle 0 is the cycle after the edge that accepts req_valid. In steal or no-handshake mode, bus_req and the lane, address and write fields are due in cycle 0. In wait mode they are due in the same cycle as the first bus_idle. done and rdata are due one cycle after bus_req, and an abort shows done, ack_err_long and sts_noresp in cycle 512. The bench drives inputs on the falling edge and samples one time unit later. Each check therefore lands on the exact cycle number counted from acceptance, including the 511 and 512 boundary and the sts_clr edge.

// File: rtl/dbs_pkg.sv
// Shared types and helpers for the debug bus access scheduler.
// Assumes byte-wide lanes on the bus data path.
package dbs_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_WORD = 2'b01,
        SZ_LONG = 2'b10,
        SZ_RSVD = 2'b11
    } size_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_WAIT = 2'b01,
        ST_GO   = 2'b10
    } state_e;

    // Number of bytes an operand occupies; the reserved code acts as long.
    function automatic int size_bytes(size_e sz, int lanes);
        case (sz)
            SZ_BYTE: return 1;
            SZ_WORD: return (lanes < 2) ? lanes : 2;
            default: return lanes;
        endcase
    endfunction
endpackage

// File: rtl/dbs_timer.sv
// Idle-wait timeout counter.
// Clears on start, counts one per enabled cycle, holds at the last value.
// expired is high in the TIMEOUT-th enabled cycle since start.
module dbs_timer #(
    parameter int TIMEOUT = 512
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic en,
    output logic expired
);
    localparam int CNT_W = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT - 1);

    logic [CNT_W-1:0] cnt;

    // Count wait cycles since the last start.
    always_ff @(posedge clk) begin
        if (!rst_n || start) cnt <= '0;
        else if (en && cnt != LAST) cnt <= cnt + 1'b1;
    end

    assign expired = (cnt == LAST);
endmodule

// File: rtl/dbs_lanes.sv
// Byte lane steering between right-aligned operands and the bus.
// Offsets are aligned down to the operand size. Purely combinational.
module dbs_lanes
    import dbs_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [$clog2(DATA_W/8)-1:0] addr_lo,
    input  size_e                       size,
    input  logic [DATA_W-1:0]           wdata,
    input  logic [DATA_W-1:0]           bus_rdata,
    output logic [DATA_W/8-1:0]         be,
    output logic [DATA_W-1:0]           bus_wdata,
    output logic [DATA_W-1:0]           rdata_al
);
    localparam int LANES = DATA_W / 8;

    int nb;
    int off;
    logic [DATA_W-1:0] keep;

    // Work out lane enables, placed write data and aligned read data.
    always_comb begin
        nb  = size_bytes(size, LANES);
        off = int'(addr_lo) & ~(nb - 1);
        for (int i = 0; i < LANES; i++) begin
            be[i]         = (i >= off) && (i < off + nb);
            keep[i*8 +: 8] = {8{i < nb}};
        end
        bus_wdata = wdata << (8 * off);
        rdata_al  = (bus_rdata >> (8 * off)) & keep;
    end
endmodule

// File: rtl/dbs_ctrl.sv
// Access sequencing: accepts one request, waits for idle or steals a cycle,
// captures read data, aborts on timeout and keeps the sticky status.
// Assumes bus_rdata is valid in the cycle bus_req is high.
module dbs_ctrl
    import dbs_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_hs_en,
    input  logic              cfg_steal,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              sts_clr,
    input  logic              bus_idle,
    input  logic              tmr_expired,
    input  logic [DATA_W-1:0] rdata_al,
    output logic              busy,
    output logic              grant,
    output logic              tmr_start,
    output logic              tmr_en,
    output logic              wait_mode,
    output logic              done,
    output logic              err_long,
    output logic              noresp,
    output logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] lat_addr,
    output size_e             lat_size,
    output logic              lat_write,
    output logic [DATA_W-1:0] lat_wdata
);
    state_e state;
    logic   abort;

    assign busy      = (state != ST_IDLE);
    assign tmr_start = (state == ST_IDLE) && req_valid;
    assign tmr_en    = (state == ST_WAIT);
    assign grant     = (state == ST_GO) || ((state == ST_WAIT) && bus_idle);
    assign abort     = (state == ST_WAIT) && !bus_idle && tmr_expired;
    assign wait_mode = (state == ST_WAIT);

    // Sequence state and one-cycle completion pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            done     <= 1'b0;
            err_long <= 1'b0;
        end else begin
            done     <= grant || abort;
            err_long <= abort;
            case (state)
                ST_IDLE: if (req_valid)
                    state <= (cfg_hs_en && !cfg_steal) ? ST_WAIT : ST_GO;
                ST_WAIT: if (grant || abort) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Latch the request fields when it is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_addr  <= '0;
            lat_size  <= SZ_BYTE;
            lat_write <= 1'b0;
            lat_wdata <= '0;
        end else if (tmr_start) begin
            lat_addr  <= req_addr;
            lat_size  <= size_e'(req_size);
            lat_write <= req_write;
            lat_wdata <= req_wdata;
        end
    end

    // Capture aligned read data in the access cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) rdata <= '0;
        else if (grant && !lat_write) rdata <= rdata_al;
    end

    // Sticky no-response flag; a new abort wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) noresp <= 1'b0;
        else if (abort) noresp <= 1'b1;
        else if (sts_clr) noresp <= 1'b0;
    end
endmodule

// File: rtl/dbg_bus_sched.sv
// Top of the debug bus access scheduler. Ties the sequencer, the timeout
// counter and the lane steering together and drives the bus master port.
// Assumes a single outstanding access and a bus that completes in one cycle.
module dbg_bus_sched
    import dbs_pkg::*;
#(
    parameter int ADDR_W  = 24,
    parameter int DATA_W  = 32,
    parameter int TIMEOUT = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_hs_en,
    input  logic              cfg_steal,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic              done,
    output logic              ack_err_long,
    output logic [DATA_W-1:0] rdata,
    output logic              sts_noresp,
    input  logic              sts_clr,
    input  logic              bus_idle,
    output logic              bus_req,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_write,
    output logic [DATA_W/8-1:0] bus_be,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata
);
    localparam int LANES = DATA_W / 8;
    localparam int OFS_W = $clog2(LANES);

    logic              grant, tmr_start, tmr_en, tmr_expired, wait_mode;
    logic [DATA_W-1:0] rdata_al, lat_wdata;
    logic [ADDR_W-1:0] lat_addr;
    size_e             lat_size;
    logic              lat_write;
    logic [LANES-1:0]  be_raw;

    dbs_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_hs_en(cfg_hs_en), .cfg_steal(cfg_steal),
        .req_valid(req_valid), .req_addr(req_addr), .req_size(req_size),
        .req_write(req_write), .req_wdata(req_wdata), .sts_clr(sts_clr),
        .bus_idle(bus_idle), .tmr_expired(tmr_expired), .rdata_al(rdata_al),
        .busy(busy), .grant(grant), .tmr_start(tmr_start), .tmr_en(tmr_en),
        .wait_mode(wait_mode), .done(done), .err_long(ack_err_long),
        .noresp(sts_noresp), .rdata(rdata), .lat_addr(lat_addr),
        .lat_size(lat_size), .lat_write(lat_write), .lat_wdata(lat_wdata)
    );

    dbs_timer #(.TIMEOUT(TIMEOUT)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(tmr_start), .en(tmr_en),
        .expired(tmr_expired)
    );

    dbs_lanes #(.DATA_W(DATA_W)) u_lanes (
        .addr_lo(lat_addr[OFS_W-1:0]), .size(lat_size), .wdata(lat_wdata),
        .bus_rdata(bus_rdata), .be(be_raw), .bus_wdata(bus_wdata),
        .rdata_al(rdata_al)
    );

    assign bus_req   = grant;
    assign bus_addr  = lat_addr;
    assign bus_write = grant && lat_write;
    assign bus_be    = grant ? be_raw : '0;
endmodule

// File: rtl/dbg_bus_sched_chk.sv
// Property checker for the debug bus access scheduler, bound to the top.
module dbg_bus_sched_chk #(
    parameter int TIMEOUT = 512,
    parameter int LANES   = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             done,
    input logic             ack_err_long,
    input logic             sts_noresp,
    input logic             sts_clr,
    input logic             bus_idle,
    input logic             bus_req,
    input logic [LANES-1:0] bus_be,
    input logic             wait_mode,
    input logic [1:0]       lat_size
);
    localparam int WC_W = $clog2(TIMEOUT + 2);
    logic [WC_W-1:0] wait_cnt;

    // Count consecutive ungranted wait cycles.
    always_ff @(posedge clk) begin
        if (!rst_n || !wait_mode || bus_req) wait_cnt <= '0;
        else wait_cnt <= wait_cnt + 1'b1;
    end

    p_wait_for_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_mode && bus_req) |-> bus_idle);
    p_req_only_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> busy);
    p_done_source_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(bus_req) || ack_err_long));
    p_err_with_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ack_err_long |-> done);
    p_wait_bounded_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wait_cnt <= WC_W'(TIMEOUT));
    p_err_sets_sts_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ack_err_long |-> sts_noresp);
    p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_noresp && !sts_clr) |=> sts_noresp);
    p_byte_lane_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && lat_size == 2'b00) |-> ($countones(bus_be) == 1));
    p_no_be_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_req |-> (bus_be == '0));
endmodule

bind dbg_bus_sched dbg_bus_sched_chk #(.TIMEOUT(TIMEOUT), .LANES(DATA_W/8)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
    .ack_err_long(ack_err_long), .sts_noresp(sts_noresp), .sts_clr(sts_clr),
    .bus_idle(bus_idle), .bus_req(bus_req), .bus_be(bus_be),
    .wait_mode(wait_mode), .lat_size(lat_size)
);

// File: tb/dbg_bus_sched_test.sv
module dbg_bus_sched_test;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] RD_PAT = 32'hA1B2C3D4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_hs_en = 1'b1, cfg_steal = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [23:0] req_addr = '0;
    logic [1:0]  req_size = 2'b00;
    logic [31:0] req_wdata = '0;
    logic        busy, done, ack_err_long, sts_noresp;
    logic [31:0] rdata;
    logic        sts_clr = 1'b0, bus_idle = 1'b0;
    logic        bus_req, bus_write;
    logic [23:0] bus_addr;
    logic [3:0]  bus_be;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata = RD_PAT;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dbg_bus_sched uut (
        .clk(clk), .rst_n(rst_n), .cfg_hs_en(cfg_hs_en), .cfg_steal(cfg_steal),
        .req_valid(req_valid), .req_addr(req_addr), .req_size(req_size),
        .req_write(req_write), .req_wdata(req_wdata), .busy(busy), .done(done),
        .ack_err_long(ack_err_long), .rdata(rdata), .sts_noresp(sts_noresp),
        .sts_clr(sts_clr), .bus_idle(bus_idle), .bus_req(bus_req),
        .bus_addr(bus_addr), .bus_write(bus_write), .bus_be(bus_be),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // Advance to the next falling edge and settle.
    task automatic step();
        @(negedge clk);
        #1;
    endtask

    // Present one request for one cycle; returns in cycle 0.
    task automatic issue(logic [23:0] a, logic [1:0] sz, logic wr, logic [31:0] wd);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_size = sz; req_write = wr; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        #1;
    endtask

    task automatic t_reset();
        step();
        chk("R1 reset bus_req", {31'b0, bus_req}, 0);
        chk("R2 reset done", {31'b0, done}, 0);
        chk("R4 reset noresp", {31'b0, sts_noresp}, 0);
        chk("R11 reset busy", {31'b0, busy}, 0);
    endtask

    task automatic t_steal_long();
        cfg_hs_en = 1; cfg_steal = 1; bus_idle = 0;
        issue(24'h123456, 2'b10, 0, 0);
        chk("R2 steal bus_req c0", {31'b0, bus_req}, 1);
        chk("R9 bus_addr", {8'b0, bus_addr}, 32'h123456);
        chk("R6 long be", {28'b0, bus_be}, 4'hF);
        step();
        chk("R2 done c1", {31'b0, done}, 1);
        chk("R7 long rdata", rdata, RD_PAT);
        step();
        chk("R2 done one cycle", {31'b0, done}, 0);
    endtask

    task automatic t_hsoff_byte();
        cfg_hs_en = 0; cfg_steal = 0; bus_idle = 0;
        issue(24'hABCDE2, 2'b00, 0, 0);
        chk("R2 hs off bus_req c0", {31'b0, bus_req}, 1);
        chk("R6 byte be lane2", {28'b0, bus_be}, 4'b0100);
        step();
        chk("R7 byte rdata", rdata, 32'h000000B2);
    endtask

    task automatic t_wait_word();
        cfg_hs_en = 1; cfg_steal = 0; bus_idle = 0;
        issue(24'h000103, 2'b01, 0, 0);
        for (int k = 0; k < 5; k++) begin
            chk("R1 no req while busy bus", {31'b0, bus_req}, 0);
            step();
        end
        bus_idle = 1; #1;
        chk("R1 req on first idle", {31'b0, bus_req}, 1);
        chk("R6 word be upper", {28'b0, bus_be}, 4'b1100);
        step();
        bus_idle = 0;
        chk("R1 done after idle grant", {31'b0, done}, 1);
        chk("R7 word rdata", rdata, 32'h0000A1B2);
    endtask

    task automatic t_write_byte();
        cfg_hs_en = 1; cfg_steal = 1; bus_idle = 0;
        issue(24'h000011, 2'b00, 1, 32'h0000005A);
        chk("R8 bus_write", {31'b0, bus_write}, 1);
        chk("R8 write lane", {24'b0, bus_wdata[15:8]}, 32'h5A);
        chk("R6 byte be lane1", {28'b0, bus_be}, 4'b0010);
        step();
    endtask

    task automatic t_size_rsvd();
        cfg_hs_en = 1; cfg_steal = 1; bus_idle = 0;
        issue(24'h000007, 2'b11, 0, 0);
        chk("R6 reserved size be", {28'b0, bus_be}, 4'hF);
        step();
        chk("R7 reserved size rdata", rdata, RD_PAT);
    endtask

    task automatic t_timeout();
        int seen = 0;
        cfg_hs_en = 1; cfg_steal = 0; bus_idle = 0;
        issue(24'h000020, 2'b10, 0, 0);
        for (int k = 0; k < 512; k++) begin
            if (bus_req || done) seen++;
            step();
        end
        chk("R3 quiet for 512 cycles", seen, 0);
        chk("R3 done at 512", {31'b0, done}, 1);
        chk("R3 long ack at 512", {31'b0, ack_err_long}, 1);
        chk("R4 noresp set", {31'b0, sts_noresp}, 1);
        step();
        chk("R3 long ack one cycle", {31'b0, ack_err_long}, 0);
    endtask

    task automatic t_edge511();
        cfg_hs_en = 1; cfg_steal = 0; bus_idle = 0;
        issue(24'h000030, 2'b10, 0, 0);
        for (int k = 0; k < 511; k++) step();
        bus_idle = 1; #1;
        chk("R3 grant at 511", {31'b0, bus_req}, 1);
        step();
        bus_idle = 0;
        chk("R3 done at 512 no err", {30'b0, done, ack_err_long}, 2'b10);
    endtask

    task automatic t_sticky();
        cfg_hs_en = 1; cfg_steal = 1; bus_idle = 0;
        issue(24'h000040, 2'b10, 0, 0);
        step();
        chk("R4 noresp kept after success", {31'b0, sts_noresp}, 1);
        @(negedge clk); sts_clr = 1;
        @(negedge clk); sts_clr = 0; #1;
        chk("R5 noresp cleared", {31'b0, sts_noresp}, 0);
    endtask

    task automatic t_restart();
        int seen = 0;
        cfg_hs_en = 1; cfg_steal = 0; bus_idle = 0;
        issue(24'h000050, 2'b10, 0, 0);
        for (int k = 0; k < 300; k++) step();
        bus_idle = 1; step(); bus_idle = 0;
        issue(24'h000060, 2'b10, 0, 0);
        for (int k = 0; k < 512; k++) begin
            if (done) seen++;
            step();
        end
        chk("R10 full window after restart", seen, 0);
        chk("R10 abort at 512", {31'b0, ack_err_long}, 1);
        @(negedge clk); sts_clr = 1;
        @(negedge clk); sts_clr = 0;
    endtask

    task automatic t_ignore();
        cfg_hs_en = 1; cfg_steal = 0; bus_idle = 0;
        issue(24'h000070, 2'b00, 0, 0);
        @(negedge clk);
        req_valid = 1; req_addr = 24'hFFFFFF; req_size = 2'b10;
        @(negedge clk);
        req_valid = 0; bus_idle = 1; #1;
        chk("R11 addr kept", {8'b0, bus_addr}, 32'h000070);
        chk("R11 size kept", {28'b0, bus_be}, 4'b0001);
        step();
        bus_idle = 0;
        step();
        chk("R11 no second access", {31'b0, busy}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_steal_long();
        t_hsoff_byte();
        t_wait_word();
        t_write_byte();
        t_size_rsvd();
        t_timeout();
        t_sticky();
        t_edge511();
        t_restart();
        t_ignore();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule